// File: doc/BRIEF.md
# Variable Block Size SAD Motion Search

This block scores candidate displacements of a 32×32 current macroblock against a reference area with the sum of absolute differences (SAD). It does this for many block sizes in the same pass. Each candidate arrives as four beats, one for each 16×16 quadrant of the macroblock. A beat carries the current-block tile, the displaced reference tile, a per-pixel object mask and the displacement. A 16×16 array of absolute-difference cells reduces each beat to sixteen 4×4 costs, then four 8×8 costs, then one 16×16 cost. A register sums the four quadrant costs of a candidate into the 32×32 cost. A selectable group of 8×8 blocks inside each quadrant forms a partial-quadtree segment cost.

For every block position at every level, a tracker keeps the lowest cost seen since the last start pulse and the displacement that produced it. The driver enumerates the displacements, normally every integer vector from -32 to +32 on both axes in raster order. It flags the final candidate. Once that candidate has been scored, the block raises a one-cycle completion pulse.

Top module: `vbs_sad_search`

## Requirements
- R1: The per-pixel term is |cur − cand| on 8-bit unsigned values. A pixel whose mask bit is 0 (outside the object) contributes 0 to every cost that covers it. A mask bit of 1 means the pixel is inside the object.
- R2: A 4×4 cost is the sum of its 16 pixel terms. The 64 positions are numbered row*8+col over the 32×32 block, where row and col are 4-pixel units counted from the top left.
- R3: An 8×8 cost is the sum of its four 4×4 costs. The 16 positions are numbered row*4+col in 8-pixel units.
- R4: Each candidate is presented as four beats with quadrant index 0 (top left), 1 (top right), 2 (bottom left) and 3 (bottom right), in that order. The 16×16 results are indexed by quadrant.
- R5: The 32×32 cost of a candidate is the sum of its four quadrant costs.
- R6: The segment cost of quadrant q is the sum of those 8×8 costs inside q whose bit k is set in seg_sel_i. Here k = row*2+col inside the quadrant.
- R7: A candidate replaces a stored best only when its cost is strictly lower. On a tie, the earliest presented candidate is kept.
- R8: A vector is reported as 14 bits. Bits [13:7] hold the vertical component and bits [6:0] the horizontal component, each in 7-bit two's complement. The full range of -32 to +32 is accepted.
- R9: Reset and start_i set every cost to 262143 (all ones in 18 bits), every vector to 0, and done_o to 0.
- R10: done_o is high for exactly one cycle, two cycles after the clock edge that accepts the beat with quadrant 3 and beat_last_i set. Results then hold until the next start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears all trackers for a new search |
| beat_vld_i | input | 1 | A quadrant beat is present |
| beat_quad_i | input | 2 | Quadrant index of the beat |
| beat_last_i | input | 1 | Beat belongs to the final candidate |
| dx_i | input | 7 | Horizontal displacement, signed |
| dy_i | input | 7 | Vertical displacement, signed |
| cur_i | input | 2048 | Current tile, pixel r*16+c at bits [(r*16+c)*8 +: 8] |
| cand_i | input | 2048 | Displaced reference tile, same packing |
| mask_i | input | 256 | Object mask, bit r*16+c |
| seg_sel_i | input | 4 | 8×8 blocks in the segment of each quadrant |
| done_o | output | 1 | Search complete pulse |
| cost4_o | output | 1152 | 64 best 4×4 costs, 18 bits each |
| mv4_o | output | 896 | 64 best 4×4 vectors, 14 bits each |
| cost8_o | output | 288 | 16 best 8×8 costs |
| mv8_o | output | 224 | 16 best 8×8 vectors |
| cost16_o | output | 72 | 4 best 16×16 costs |
| mv16_o | output | 56 | 4 best 16×16 vectors |
| costseg_o | output | 72 | 4 best segment costs |
| mvseg_o | output | 56 | 4 best segment vectors |
| cost32_o | output | 18 | Best 32×32 cost |
| mv32_o | output | 14 | Best 32×32 vector |

## Verification
A beat accepted at clock edge E is reduced and registered at E, and it updates the trackers at E+1. The trackers are visible one cycle after the beat was driven plus one more. done_o is therefore high in the cycle after edge E+1 that follows the final beat. The bench drives on falling edges and samples on falling edges. It checks that done_o is low one falling edge after the final beat, high on the next, and low again on the one after. The scoreboard monitor pops and compares all 89 expected results on the falling edge where done_o is seen high. The bench also checks the cleared tracker state one falling edge after start_i and re-checks the held 32×32 result several cycles after completion.

// File: rtl/vbs_pkg.sv
`timescale 1ns/1ps
// vbs_pkg: shared sizes for the variable block size SAD search.
// Assumes a square tile whose side is a multiple of twice the leaf size.
package vbs_pkg;
    parameter int TILE   = 16;   // pixels per tile side (one quadrant)
    parameter int SUB    = 4;    // leaf block side
    parameter int PIX_W  = 8;    // luma width
    parameter int MV_W   = 7;    // one vector component
    parameter int COST_W = 18;   // covers 1024 * 255

    localparam int NS     = TILE / SUB;        // leaves per tile side
    localparam int NB4T   = NS * NS;           // leaves per tile
    localparam int S8     = NS / 2;            // leaves per 8x8 side
    localparam int NB8T   = 4;                 // 8x8 blocks per tile
    localparam int NPIX   = TILE * TILE;
    localparam int NB4    = 4 * NB4T;          // leaves in 32x32
    localparam int NB8    = 4 * NB8T;
    localparam int MVP_W  = 2 * MV_W;
    localparam logic [COST_W-1:0] MAX_COST = '1;

    // pixel index of element i of leaf b inside a tile
    function automatic int pix_of(int b, int i);
        return ((b / NS) * SUB + i / SUB) * TILE + (b % NS) * SUB + i % SUB;
    endfunction
endpackage

// File: rtl/vbs_sad_tile.sv
`timescale 1ns/1ps
// vbs_sad_tile: combinational masked absolute-difference array and
// quadtree adder for one tile. Produces leaf, 8x8 and full-tile costs.
// Assumes packed pixel p = r*TILE+c; mask bit 1 keeps the pixel.
module vbs_sad_tile
    import vbs_pkg::*;
(
    input  logic [NPIX*PIX_W-1:0]           cur_i,
    input  logic [NPIX*PIX_W-1:0]           cand_i,
    input  logic [NPIX-1:0]                 mask_i,
    output logic [NB4T-1:0][COST_W-1:0]     s4_o,
    output logic [NB8T-1:0][COST_W-1:0]     s8_o,
    output logic [COST_W-1:0]               s16_o
);
    logic [NPIX-1:0][PIX_W-1:0] ad_w;

    for (genvar p = 0; p < NPIX; p++) begin : g_ad
        logic [PIX_W-1:0] a_w, b_w;
        assign a_w = cur_i[p*PIX_W +: PIX_W];
        assign b_w = cand_i[p*PIX_W +: PIX_W];
        // masked absolute difference of one pixel
        assign ad_w[p] = !mask_i[p] ? '0 : (a_w > b_w) ? (a_w - b_w) : (b_w - a_w);
    end

    for (genvar b = 0; b < NB4T; b++) begin : g_s4
        logic [COST_W-1:0] sum_l;
        // leaf sum over its SUB*SUB pixels
        always_comb begin
            sum_l = '0;
            for (int i = 0; i < SUB*SUB; i++)
                sum_l = sum_l + COST_W'(ad_w[pix_of(b, i)]);
        end
        assign s4_o[b] = sum_l;
    end

    for (genvar k = 0; k < NB8T; k++) begin : g_s8
        localparam int BASE = (k / 2) * S8 * NS + (k % 2) * S8;
        logic [COST_W-1:0] sum_l;
        // 8x8 sum of its leaves
        always_comb begin
            sum_l = '0;
            for (int r = 0; r < S8; r++)
                for (int c = 0; c < S8; c++)
                    sum_l = sum_l + s4_o[BASE + r*NS + c];
        end
        assign s8_o[k] = sum_l;
    end

    assign s16_o = s8_o[0] + s8_o[1] + s8_o[2] + s8_o[3];

    // R1
    always_comb begin
        if (mask_i == '0) begin
            zero_mask_chk: assert (s16_o == '0);
        end
    end
endmodule

// File: rtl/vbs_best_keep.sv
`timescale 1ns/1ps
// vbs_best_keep: holds the lowest cost and its vector for one block
// position. Replaces only on a strictly lower cost, so ties keep the
// earlier candidate. Assumes clr_i and upd_i come from the search control.
module vbs_best_keep
    import vbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [COST_W-1:0] cost_i,
    input  logic [MVP_W-1:0]  mv_i,
    output logic [COST_W-1:0] cost_o,
    output logic [MVP_W-1:0]  mv_o
);
    // keep the minimum since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cost_o <= MAX_COST;
            mv_o   <= '0;
        end else if (upd_i && cost_i < cost_o) begin
            cost_o <= cost_i;
            mv_o   <= mv_i;
        end
    end

    // R7
    cost_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cost_o <= $past(cost_o));
    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !upd_i) |=> ($stable(cost_o) && $stable(mv_o)));
endmodule

// File: rtl/vbs_sad_search.sv
`timescale 1ns/1ps
// vbs_sad_search: variable block size SAD search over quadrant beats.
// Stage 1 registers the tile costs of a beat; stage 2 accumulates the
// 32x32 cost and updates one tracker per block position and level.
// Assumes beats of a candidate arrive as quadrants 0,1,2,3 and that
// seg_sel_i is held during a search.
module vbs_sad_search
    import vbs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      beat_vld_i,
    input  logic [1:0]                beat_quad_i,
    input  logic                      beat_last_i,
    input  logic [MV_W-1:0]           dx_i,
    input  logic [MV_W-1:0]           dy_i,
    input  logic [NPIX*PIX_W-1:0]     cur_i,
    input  logic [NPIX*PIX_W-1:0]     cand_i,
    input  logic [NPIX-1:0]           mask_i,
    input  logic [NB8T-1:0]           seg_sel_i,
    output logic                      done_o,
    output logic [NB4*COST_W-1:0]     cost4_o,
    output logic [NB4*MVP_W-1:0]      mv4_o,
    output logic [NB8*COST_W-1:0]     cost8_o,
    output logic [NB8*MVP_W-1:0]      mv8_o,
    output logic [4*COST_W-1:0]       cost16_o,
    output logic [4*MVP_W-1:0]        mv16_o,
    output logic [4*COST_W-1:0]       costseg_o,
    output logic [4*MVP_W-1:0]        mvseg_o,
    output logic [COST_W-1:0]         cost32_o,
    output logic [MVP_W-1:0]          mv32_o
);
    logic [NB4T-1:0][COST_W-1:0] s4_w, s4_q;
    logic [NB8T-1:0][COST_W-1:0] s8_w, s8_q;
    logic [COST_W-1:0]           s16_w, s16_q, acc32_q, tot32_w, seg_w;
    logic [1:0]                  quad_q, nxt_quad_q;
    logic [MVP_W-1:0]            mv_q;
    logic                        vld_q, last_q;

    vbs_sad_tile i_tile (
        .cur_i  (cur_i),
        .cand_i (cand_i),
        .mask_i (mask_i),
        .s4_o   (s4_w),
        .s8_o   (s8_w),
        .s16_o  (s16_w)
    );

    // stage 1: capture tile costs and beat tags
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) vld_q <= 1'b0;
        else                   vld_q <= beat_vld_i;
        s4_q   <= s4_w;
        s8_q   <= s8_w;
        s16_q  <= s16_w;
        quad_q <= beat_quad_i;
        last_q <= beat_last_i;
        mv_q   <= {dy_i, dx_i};
    end

    // expected quadrant of the next beat
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) nxt_quad_q <= 2'd0;
        else if (beat_vld_i)   nxt_quad_q <= beat_quad_i + 2'd1;
    end

    assign tot32_w = ((quad_q == 2'd0) ? '0 : acc32_q) + s16_q;

    // stage 2: 32x32 accumulation across the four quadrant beats
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) acc32_q <= '0;
        else if (vld_q)        acc32_q <= tot32_w;
    end

    // completion pulse after the final quadrant has been compared
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) done_o <= 1'b0;
        else                   done_o <= vld_q && (quad_q == 2'd3) && last_q;
    end

    // segment cost: selected 8x8 blocks of the current quadrant
    always_comb begin
        seg_w = '0;
        for (int k = 0; k < NB8T; k++)
            if (seg_sel_i[k]) seg_w = seg_w + s8_q[k];
    end

    for (genvar g = 0; g < NB4; g++) begin : g_b4
        localparam int GR = g / (2*NS);
        localparam int GC = g % (2*NS);
        localparam int QD = (GR / NS) * 2 + GC / NS;
        localparam int LB = (GR % NS) * NS + GC % NS;
        vbs_best_keep i_keep (
            .clk (clk), .rst_n (rst_n), .clr_i (start_i),
            .upd_i (vld_q && quad_q == 2'(QD)), .cost_i (s4_q[LB]), .mv_i (mv_q),
            .cost_o (cost4_o[g*COST_W +: COST_W]), .mv_o (mv4_o[g*MVP_W +: MVP_W])
        );
    end

    for (genvar g = 0; g < NB8; g++) begin : g_b8
        localparam int GR = g / 4;
        localparam int GC = g % 4;
        localparam int QD = (GR / 2) * 2 + GC / 2;
        localparam int LB = (GR % 2) * 2 + GC % 2;
        vbs_best_keep i_keep (
            .clk (clk), .rst_n (rst_n), .clr_i (start_i),
            .upd_i (vld_q && quad_q == 2'(QD)), .cost_i (s8_q[LB]), .mv_i (mv_q),
            .cost_o (cost8_o[g*COST_W +: COST_W]), .mv_o (mv8_o[g*MVP_W +: MVP_W])
        );
    end

    for (genvar g = 0; g < 4; g++) begin : g_b16
        vbs_best_keep i_keep16 (
            .clk (clk), .rst_n (rst_n), .clr_i (start_i),
            .upd_i (vld_q && quad_q == 2'(g)), .cost_i (s16_q), .mv_i (mv_q),
            .cost_o (cost16_o[g*COST_W +: COST_W]), .mv_o (mv16_o[g*MVP_W +: MVP_W])
        );
        vbs_best_keep i_keepseg (
            .clk (clk), .rst_n (rst_n), .clr_i (start_i),
            .upd_i (vld_q && quad_q == 2'(g)), .cost_i (seg_w), .mv_i (mv_q),
            .cost_o (costseg_o[g*COST_W +: COST_W]), .mv_o (mvseg_o[g*MVP_W +: MVP_W])
        );
    end

    vbs_best_keep i_keep32 (
        .clk (clk), .rst_n (rst_n), .clr_i (start_i),
        .upd_i (vld_q && quad_q == 2'd3), .cost_i (tot32_w), .mv_i (mv_q),
        .cost_o (cost32_o), .mv_o (mv32_o)
    );

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4
    quad_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_i && !start_i) |-> beat_quad_i == nxt_quad_q);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !start_i && quad_q != 2'd0) |=> acc32_q >= $past(acc32_q));
endmodule

// File: tb/test_vbs_sad_search.sv
`timescale 1ns/1ps
module test_vbs_sad_search;
    localparam int CW = 18;
    localparam int MW = 14;
    localparam logic [CW-1:0] MAXC = '1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bvld = 1'b0, blast = 1'b0;
    logic [1:0] bquad = '0;
    logic [6:0] dx = '0, dy = '0;
    logic [2047:0] cur_bus = '0, cand_bus = '0;
    logic [255:0] mask_bus = '0;
    logic [3:0] seg_sel = '0;
    logic done;
    logic [64*CW-1:0] c4;  logic [64*MW-1:0] m4;
    logic [16*CW-1:0] c8;  logic [16*MW-1:0] m8;
    logic [4*CW-1:0] c16, cseg; logic [4*MW-1:0] m16, mseg;
    logic [CW-1:0] c32; logic [MW-1:0] m32;

    always #2 clk = ~clk;

    vbs_sad_search i_vbs_sad_search (
        .clk(clk), .rst_n(rst_n), .start_i(start), .beat_vld_i(bvld),
        .beat_quad_i(bquad), .beat_last_i(blast), .dx_i(dx), .dy_i(dy),
        .cur_i(cur_bus), .cand_i(cand_bus), .mask_i(mask_bus), .seg_sel_i(seg_sel),
        .done_o(done), .cost4_o(c4), .mv4_o(m4), .cost8_o(c8), .mv8_o(m8),
        .cost16_o(c16), .mv16_o(m16), .costseg_o(cseg), .mvseg_o(mseg),
        .cost32_o(c32), .mv32_o(m32));

    typedef struct { int lvl; int idx; logic [CW-1:0] cost; logic [MW-1:0] mv; } item_t;
    item_t sbq[$];

    int checks = 0, fails = 0;
    string tag = "";
    logic [7:0] ref_img [0:95][0:95];
    logic [7:0] cur_img [0:31][0:31];
    logic       msk     [0:31][0:31];
    logic [CW-1:0] e32; logic [MW-1:0] em32;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when the completion pulse is seen
    always @(negedge clk) begin
        if (rst_n && done) begin
            while (sbq.size() > 0) begin
                item_t it;
                logic [CW-1:0] ac; logic [MW-1:0] am;
                string req;
                it = sbq.pop_front();
                case (it.lvl)
                    0: begin ac = c4[it.idx*CW +: CW]; am = m4[it.idx*MW +: MW]; req = "R2"; end
                    1: begin ac = c8[it.idx*CW +: CW]; am = m8[it.idx*MW +: MW]; req = "R3"; end
                    2: begin ac = c16[it.idx*CW +: CW]; am = m16[it.idx*MW +: MW]; req = "R4"; end
                    3: begin ac = cseg[it.idx*CW +: CW]; am = mseg[it.idx*MW +: MW]; req = "R6"; end
                    default: begin ac = c32; am = m32; req = "R5"; end
                endcase
                chk(ac == it.cost, req, $sformatf("cost lvl%0d idx%0d", it.lvl, it.idx), ac, it.cost);
                // R7 R8: vector of the first strict minimum
                chk(am == it.mv, "R8", $sformatf("mv lvl%0d idx%0d", it.lvl, it.idx), am, it.mv);
            end
        end
    end

    // driver: builds the full-search model, queues it, then drives beats
    task automatic run_search(input int lx, input int hx, input int ly, input int hy,
                              input logic [3:0] sel, input string t);
        logic [CW-1:0] b4 [64]; logic [MW-1:0] v4 [64];
        logic [CW-1:0] b8 [16]; logic [MW-1:0] v8 [16];
        logic [CW-1:0] b16 [4]; logic [MW-1:0] v16 [4];
        logic [CW-1:0] bs [4];  logic [MW-1:0] vs [4];
        logic [CW-1:0] b32; logic [MW-1:0] v32;
        tag = t;
        for (int i = 0; i < 64; i++) begin b4[i] = MAXC; v4[i] = '0; end
        for (int i = 0; i < 16; i++) begin b8[i] = MAXC; v8[i] = '0; end
        for (int i = 0; i < 4; i++) begin b16[i] = MAXC; v16[i] = '0; bs[i] = MAXC; vs[i] = '0; end
        b32 = MAXC; v32 = '0;
        for (int vy = ly; vy <= hy; vy++) begin
            for (int vx = lx; vx <= hx; vx++) begin
                int s4 [64]; int s8 [16]; int s16 [4]; int ss [4]; int s32;
                logic [MW-1:0] mv;
                mv = {7'(vy), 7'(vx)};
                for (int i = 0; i < 64; i++) s4[i] = 0;
                for (int i = 0; i < 16; i++) s8[i] = 0;
                for (int i = 0; i < 4; i++) begin s16[i] = 0; ss[i] = 0; end
                s32 = 0;
                for (int y = 0; y < 32; y++) begin
                    for (int x = 0; x < 32; x++) begin
                        int a, b, d, q, k;
                        a = int'(cur_img[y][x]);
                        b = int'(ref_img[32+y+vy][32+x+vx]);
                        d = msk[y][x] ? ((a > b) ? a - b : b - a) : 0;
                        q = (y/16)*2 + x/16;
                        k = ((y/8)%2)*2 + (x/8)%2;
                        s4[(y/4)*8 + x/4] += d;
                        s8[(y/8)*4 + x/8] += d;
                        s16[q] += d;
                        if (sel[k]) ss[q] += d;
                        s32 += d;
                    end
                end
                for (int i = 0; i < 64; i++) if (CW'(s4[i]) < b4[i]) begin b4[i] = CW'(s4[i]); v4[i] = mv; end
                for (int i = 0; i < 16; i++) if (CW'(s8[i]) < b8[i]) begin b8[i] = CW'(s8[i]); v8[i] = mv; end
                for (int i = 0; i < 4; i++) begin
                    if (CW'(s16[i]) < b16[i]) begin b16[i] = CW'(s16[i]); v16[i] = mv; end
                    if (CW'(ss[i]) < bs[i]) begin bs[i] = CW'(ss[i]); vs[i] = mv; end
                end
                if (CW'(s32) < b32) begin b32 = CW'(s32); v32 = mv; end
            end
        end
        for (int i = 0; i < 64; i++) sbq.push_back('{0, i, b4[i], v4[i]});
        for (int i = 0; i < 16; i++) sbq.push_back('{1, i, b8[i], v8[i]});
        for (int i = 0; i < 4; i++)  sbq.push_back('{2, i, b16[i], v16[i]});
        for (int i = 0; i < 4; i++)  sbq.push_back('{3, i, bs[i], vs[i]});
        sbq.push_back('{4, 0, b32, v32});
        e32 = b32; em32 = v32;

        @(negedge clk); seg_sel = sel; start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R9: trackers cleared by start
        chk(c32 == MAXC, "R9", "cost32 after start", c32, MAXC);
        chk(m4[5*MW +: MW] == '0, "R9", "mv4 after start", m4[5*MW +: MW], 0);
        for (int vy = ly; vy <= hy; vy++) begin
            for (int vx = lx; vx <= hx; vx++) begin
                for (int q = 0; q < 4; q++) begin
                    for (int r = 0; r < 16; r++) begin
                        for (int c = 0; c < 16; c++) begin
                            int y, x;
                            y = (q/2)*16 + r; x = (q%2)*16 + c;
                            cur_bus[(r*16+c)*8 +: 8]  = cur_img[y][x];
                            cand_bus[(r*16+c)*8 +: 8] = ref_img[32+y+vy][32+x+vx];
                            mask_bus[r*16+c]          = msk[y][x];
                        end
                    end
                    bvld = 1'b1; bquad = 2'(q); dx = 7'(vx); dy = 7'(vy);
                    blast = (vy == hy) && (vx == hx);
                    @(negedge clk);
                end
            end
        end
        bvld = 1'b0; blast = 1'b0;
        // R10: pulse timing relative to the final beat
        chk(done == 1'b0, "R10", "done early", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R10", "done due", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        chk(sbq.size() == 0, "R10", "scoreboard drained", sbq.size(), 0);
        repeat (4) @(negedge clk);
        chk(c32 == e32 && m32 == em32, "R10", "result held", c32, e32);
    endtask

    initial begin
        #(190000 * 4);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(done == 1'b0, "R9", "done in reset", done, 0);
        chk(c32 == MAXC, "R9", "cost32 in reset", c32, MAXC);
        rst_n = 1'b1;
        @(negedge clk);

        // pure shift, full exhaustive window
        for (int y = 0; y < 96; y++) for (int x = 0; x < 96; x++) ref_img[y][x] = 8'($urandom);
        for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) begin
            cur_img[y][x] = ref_img[32+y-3][32+x+5]; msk[y][x] = 1'b1;
        end
        run_search(-32, 32, -32, 32, 4'b0110, "R2 shift");

        // R1: random content and random mask
        for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) begin
            cur_img[y][x] = 8'($urandom); msk[y][x] = 1'($urandom);
        end
        run_search(-3, 3, -3, 3, 4'b1001, "R1 random mask");

        // R1 R7: every pixel outside the object, all costs zero, first vector kept
        for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) msk[y][x] = 1'b0;
        run_search(-2, 1, -2, 1, 4'b1111, "R1 all masked");

        // R7 R8: flat images tie everywhere, extreme displacements
        for (int y = 0; y < 96; y++) for (int x = 0; x < 96; x++) ref_img[y][x] = 8'd77;
        for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) begin
            cur_img[y][x] = 8'd77; msk[y][x] = 1'b1;
        end
        run_search(-32, -30, 30, 32, 4'b0011, "R7 tie");

        // R5 R6: near-shift with noise and a partial mask
        for (int y = 0; y < 96; y++) for (int x = 0; x < 96; x++) ref_img[y][x] = 8'($urandom);
        for (int y = 0; y < 32; y++) for (int x = 0; x < 32; x++) begin
            cur_img[y][x] = ref_img[32+y+1][32+x-2] ^ 8'($urandom_range(0, 3));
            msk[y][x] = (x + y) % 5 != 0;
        end
        run_search(-4, 4, -4, 4, 4'b1010, "R6 noisy");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule